// File: doc/BRIEF.md
# Single-Bit Manipulation and Test Unit

This block is an execute helper inside an 8-bit processor core. It handles the bit instructions: clearing or setting a single memory bit, branching on the state of a single memory bit, and the accumulator-masked test-and-set and test-and-reset operations. The core's sequencer presents the opcode, the fetched memory operand, the accumulator and the flag-based branch condition it already computes, then pulses a start strobe. One cycle later the unit returns a done pulse together with the results:
- the byte to write back, with a write-enable;
- a branch-taken bit;
- a zero-flag value, with a strobe that updates the zero flag alone.

The bit number comes from opcode bits 6:4. One decoder turns it into a one-hot mask, and one 8:1 selector picks the tested operand bit. Setting and clearing share a single OR/AND path. Branch-on-set and branch-on-clear share one selector: the operand is inverted before the selector when the branch tests for a clear bit. For any opcode outside the bit group, the branch output passes on the core's own flag-based condition, so the sequencer sees one merged taken/not-taken signal.

Top module: `bitop_unit`

## Requirements
- R1: While rst_ni is low and after release with no start, done_o, wr_en_o, z_upd_o, branch_o, wr_data_o and z_o are all 0.
- R2: done_o is 1 in exactly the cycle after each cycle with start_i high, and 0 otherwise. All other outputs change only at those edges.
- R3: For a bit-clear opcode (low nibble 0x7, bit 7 = 0), wr_data_o = operand AND NOT (1 << opcode[6:4]) and wr_en_o = 1.
- R4: For a bit-set opcode (low nibble 0x7, bit 7 = 1), wr_data_o = operand OR (1 << opcode[6:4]) and wr_en_o = 1.
- R5: For a branch-on-clear opcode (low nibble 0xF, bit 7 = 0), branch_o = NOT operand[opcode[6:4]], and wr_en_o = 0.
- R6: For a branch-on-set opcode (low nibble 0xF, bit 7 = 1), branch_o = operand[opcode[6:4]], and wr_en_o = 0.
- R7: For every opcode outside the bit-branch group, branch_o equals flag_cond_i as sampled with start_i.
- R8: For test-and-set opcodes 0x04 and 0x0C, wr_data_o = operand OR accumulator, wr_en_o = 1, z_upd_o = 1, and z_o = 1 exactly when (accumulator AND operand) is zero.
- R9: For test-and-reset opcodes 0x14 and 0x1C, wr_data_o = operand AND NOT accumulator, wr_en_o = 1, z_upd_o = 1, and z_o follows the same rule as in R8.
- R10: z_upd_o is 1 only for the opcodes of R8 and R9. Opcodes outside R3, R4, R8 and R9 (for example 0xEA, and every low-nibble-0xF opcode) give wr_en_o = 0 and z_upd_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts one operation on the sampled inputs |
| opcode_i | input | 8 | Instruction opcode |
| operand_i | input | 8 | Memory operand byte |
| acc_i | input | 8 | Accumulator value |
| flag_cond_i | input | 1 | Flag-based branch condition from the core |
| done_o | output | 1 | Result-valid pulse, one cycle after start |
| wr_data_o | output | 8 | Byte to write back |
| wr_en_o | output | 1 | Write-back enable, valid with done_o |
| branch_o | output | 1 | Merged branch-taken decision |
| z_o | output | 1 | Zero-flag result |
| z_upd_o | output | 1 | Zero-only flag update strobe, valid with done_o |

## Verification
The bit-modify and bit-branch groups are swept over all eight bit indices and all 256 operand values, in both polarities. This tells a wrong mask bit, a swapped index, or a missing inversion apart from a correct result, because every operand bit is both 0 and 1 under every index. The test operations use operand and accumulator pairs that do and do not overlap, including zero and all-ones, which separates the zero rule from the written byte and the set form from the reset form. Opcodes outside the group are run with both flag-condition values, which shows that the merged branch passes the condition through and that nothing is written.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_BMOD = 2'd1,
    CLS_BBR  = 2'd2,
    CLS_TST  = 2'd3
  } op_cls_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned IDX_W_P = 3,
  parameter int unsigned IDX_LSB = 4
) (
  input  logic [OPC_W-1:0]   opcode_i,
  output op_cls_e            cls_o,
  output logic               set_o,
  output logic [IDX_W_P-1:0] idx_o
);
  localparam logic [OPC_W-1:0] TST_MASK = OPC_W'(8'hE7);
  localparam logic [OPC_W-1:0] TST_BASE = OPC_W'(8'h04);

  always_comb begin
    cls_o = CLS_NONE;
    set_o = opcode_i[OPC_W-1];
    if (opcode_i[3:0] == 4'h7) begin
      cls_o = CLS_BMOD;
    end else if (opcode_i[3:0] == 4'hF) begin
      cls_o = CLS_BBR;
    end else if ((opcode_i & TST_MASK) == TST_BASE) begin
      cls_o = CLS_TST;
      set_o = ~opcode_i[4];   // 0x04/0x0C set, 0x14/0x1C reset
    end
  end

  assign idx_o = opcode_i[IDX_LSB +: IDX_W_P];
endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/bitop_select.sv
module bitop_select #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              invert_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] cond_data;
  assign cond_data = data_i ^ {DATA_W{invert_i}};
  assign bit_o     = cond_data[idx_i];
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned IDX_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              flag_cond_i,
  output logic              done_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic              branch_o,
  output logic              z_o,
  output logic              z_upd_o
);
  op_cls_e           cls;
  logic              set_op;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] onehot;
  logic [DATA_W-1:0] mod_mask;
  logic [DATA_W-1:0] new_byte;
  logic              test_bit;
  logic              z_res;
  logic              writes;

  bitop_decode #(.OPC_W(OPC_W), .IDX_W_P(IDX_W), .IDX_LSB(IDX_LSB)) u_dec (
    .opcode_i (opcode_i),
    .cls_o    (cls),
    .set_o    (set_op),
    .idx_o    (idx)
  );

  bitop_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx_i  (idx),
    .mask_o (onehot)
  );

  // branch-on-clear tests the inverted operand
  bitop_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .data_i   (operand_i),
    .invert_i (~set_op),
    .idx_i    (idx),
    .bit_o    (test_bit)
  );

  // one OR/AND path for both set and clear, mask from decoder or accumulator
  assign mod_mask = (cls == CLS_TST) ? acc_i : onehot;
  assign new_byte = set_op ? (operand_i | mod_mask) : (operand_i & ~mod_mask);
  assign z_res    = ~|(acc_i & operand_i);
  assign writes   = (cls == CLS_BMOD) || (cls == CLS_TST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      wr_data_o <= '0;
      wr_en_o   <= 1'b0;
      branch_o  <= 1'b0;
      z_o       <= 1'b0;
      z_upd_o   <= 1'b0;
    end else if (start_i) begin
      done_o   <= 1'b1;
      wr_en_o  <= writes;
      z_upd_o  <= (cls == CLS_TST);
      branch_o <= (cls == CLS_BBR) ? test_bit : flag_cond_i;
      if (writes)         wr_data_o <= new_byte;
      if (cls == CLS_TST) z_o       <= z_res;
    end else begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      z_upd_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bitop_checker.sv
module bitop_checker #(
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              done_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_en_o,
  input logic              z_o,
  input logic              z_upd_o
);
  logic is_bmod, is_bbr, is_tst;
  assign is_bmod = opcode_i[3:0] == 4'h7;
  assign is_bbr  = opcode_i[3:0] == 4'hF;
  assign is_tst  = (opcode_i & 8'hE7) == 8'h04;

  p_done_follows_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_done_needs_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_wr_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  p_zupd_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_upd_o |-> done_o);

  p_branch_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_bbr) |=> (!wr_en_o && !z_upd_o));

  p_clear_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_bmod && !opcode_i[7]) |=>
      (wr_en_o && wr_data_o[$past(opcode_i[6:4])] == 1'b0));

  p_set_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_bmod && opcode_i[7]) |=>
      (wr_en_o && wr_data_o[$past(opcode_i[6:4])] == 1'b1));

  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && is_tst) |=>
      (z_upd_o && z_o == (($past(acc_i) & $past(operand_i)) == '0)));
endmodule

bind bitop_unit bitop_checker #(.OPC_W(OPC_W), .DATA_W(bitop_pkg::DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .opcode_i  (opcode_i),
  .operand_i (operand_i),
  .acc_i     (acc_i),
  .done_o    (done_o),
  .wr_data_o (wr_data_o),
  .wr_en_o   (wr_en_o),
  .z_o       (z_o),
  .z_upd_o   (z_upd_o)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc = 8'h00;
  logic       flag_cond = 1'b0;
  logic       done, wr_en, branch, z, z_upd;
  logic [7:0] wr_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitop_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .operand_i(operand), .acc_i(acc), .flag_cond_i(flag_cond),
    .done_o(done), .wr_data_o(wr_data), .wr_en_o(wr_en), .branch_o(branch),
    .z_o(z), .z_upd_o(z_upd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s opc=%02h opr=%02h acc=%02h act=%02h exp=%02h",
               req, opcode, operand, acc, act, exp);
    end
  endtask

  // one start pulse; returns at the negedge after the result edge
  task automatic issue(input logic [7:0] opc, input logic [7:0] opr,
                       input logic [7:0] a, input logic fc);
    @(negedge clk);
    opcode = opc; operand = opr; acc = a; flag_cond = fc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", {7'd0, done}, 8'd0);
    chk("R1 wr_en", {7'd0, wr_en}, 8'd0);
    chk("R1 z_upd", {7'd0, z_upd}, 8'd0);
    chk("R1 branch", {7'd0, branch}, 8'd0);
    chk("R1 wr_data", wr_data, 8'd0);
    chk("R1 z", {7'd0, z}, 8'd0);
  endtask

  task automatic t_latency;
    issue(8'h17, 8'hFF, 8'h00, 1'b0);
    chk("R2 done high", {7'd0, done}, 8'd1);
    @(negedge clk);
    chk("R2 done low", {7'd0, done}, 8'd0);
    chk("R2 wr_en low", {7'd0, wr_en}, 8'd0);
    chk("R2 data held", wr_data, 8'hFD);
  endtask

  task automatic t_modify(input bit set);
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] m, e;
        m = 8'(1 << i);
        e = set ? (8'(v) | m) : (8'(v) & ~m);
        issue({set, 3'(i), 4'h7}, 8'(v), 8'(~v), v[0]);
        chk(set ? "R4 data" : "R3 data", wr_data, e);
        chk(set ? "R4 wr_en" : "R3 wr_en", {7'd0, wr_en}, 8'd1);
        chk("R10 z_upd", {7'd0, z_upd}, 8'd0);
        chk("R7 branch", {7'd0, branch}, {7'd0, v[0]});
      end
    end
  endtask

  task automatic t_branch(input bit set);
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] vv;
        logic e;
        vv = 8'(v);
        e = set ? vv[i] : ~vv[i];
        issue({set, 3'(i), 4'hF}, vv, 8'hFF, ~e);
        chk(set ? "R6 branch" : "R5 branch", {7'd0, branch}, {7'd0, e});
        chk(set ? "R6 wr_en" : "R5 wr_en", {7'd0, wr_en}, 8'd0);
        chk("R10 z_upd", {7'd0, z_upd}, 8'd0);
      end
    end
  endtask

  task automatic t_test(input logic [7:0] opc, input logic [7:0] opr, input logic [7:0] a);
    bit set;
    set = ~opc[4];
    issue(opc, opr, a, 1'b0);
    chk(set ? "R8 data" : "R9 data", wr_data, set ? (opr | a) : (opr & ~a));
    chk(set ? "R8 wr_en" : "R9 wr_en", {7'd0, wr_en}, 8'd1);
    chk(set ? "R8 z_upd" : "R9 z_upd", {7'd0, z_upd}, 8'd1);
    chk(set ? "R8 z" : "R9 z", {7'd0, z}, {7'd0, ((opr & a) == 8'd0)});
  endtask

  task automatic t_other(input logic [7:0] opc, input logic fc);
    logic [7:0] prev;
    prev = wr_data;
    issue(opc, 8'h5A, 8'hA5, fc);
    chk("R7 branch", {7'd0, branch}, {7'd0, fc});
    chk("R10 wr_en", {7'd0, wr_en}, 8'd0);
    chk("R10 z_upd", {7'd0, z_upd}, 8'd0);
    chk("R10 data held", wr_data, prev);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_modify(1'b0);
    t_modify(1'b1);
    t_branch(1'b0);
    t_branch(1'b1);
    t_test(8'h04, 8'hF0, 8'h0F);
    t_test(8'h0C, 8'h81, 8'h01);
    t_test(8'h04, 8'h00, 8'h00);
    t_test(8'h0C, 8'hFF, 8'hFF);
    t_test(8'h14, 8'hFF, 8'h3C);
    t_test(8'h1C, 8'h0F, 8'hF0);
    t_test(8'h14, 8'h00, 8'hFF);
    t_other(8'hEA, 1'b1);
    t_other(8'hEA, 1'b0);
    t_other(8'h24, 1'b1);
    t_other(8'h05, 1'b0);
    finish_run();
  end
endmodule